// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block produces a pulse-width-modulated signal for a display backlight. A base clock (nominally 6 MHz) passes through a prescaler that divides it by a programmable ratio from 1 to 128. Each prescaled tick advances an 8-bit duty counter that runs freely. The output period is therefore 256 prescaled ticks, and the output frequency is the base clock divided by (ratio × 256). A ratio of 128 on a 6 MHz base gives roughly 183 Hz.

Software programs the block through a simple write strobe. It can reach three registers: a control register, a duty register and a one-bit panel register. The control register holds an output-enable flag and a 7-bit divider code, where the code equals the ratio minus one. The divider code can only be changed while the output is disabled. To change the period, software clears the enable flag, writes the new code and then sets the enable flag again. The panel register drives a general-purpose output for a panel-enable pin and has no link to the PWM path.

Top module: `bl_pwm_top`

## Requirements
- R1: While reset is high and after it is released with no writes, `pwm_out` and `panel_en_out` are low, output enable is clear, and the divider code and the duty value are zero.
- R2: A write with `wr_sel`=0 targets the control register. Bit 7 of `wr_data` is output enable and bits 6:0 are the divider code. Ratio = code + 1, and while enabled one output period lasts 256 × ratio clock cycles.
- R3: A control write that arrives while output enable is currently set leaves the divider code unchanged, but it still updates the enable bit.
- R4: A control write that arrives while output enable is currently clear loads the divider code. This includes a write that sets enable in the same cycle.
- R5: While enabled, `pwm_out` is high exactly when the duty counter is below the active duty value. A duty of 0 keeps the output low, and a duty of 255 keeps it high for 255 of every 256 ticks.
- R6: A write with `wr_sel`=1 sets the pending duty value from `wr_data`. While enabled, the pending value becomes active only when the counter wraps from 255 to 0. While disabled, it becomes active at once, so it applies from the moment of enable.
- R7: Clearing output enable forces `pwm_out` low starting in the cycle after the write.
- R8: When output enable goes from 0 to 1, the prescaler and the duty counter restart from zero.
- R9: A write with `wr_sel`=2 sets `panel_en_out` from bit 0 of `wr_data`. The panel output neither gates `pwm_out` nor affects whether a divider code is accepted. A write with `wr_sel`=3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 duty, 2 panel, 3 none |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |
| panel_en_out | output | 1 | Panel-enable general-purpose output |

## Verification
The assertions check several rules on every cycle. They confirm that the divider code holds steady across a control write while enabled and loads while disabled. They confirm that the prescaler stays within its code, that both counters start from zero on enable, and that the active duty changes only at a wrap. They also confirm that disabling, or an active duty of zero, holds the output low. Other behaviour can only be shown by the bench scenarios, which compare the output cycle by cycle against waveforms computed from the ratio and duty. These scenarios cover the full period length for different ratios, a duty change written mid-period that takes hold at the wrap, a rejected divider change seen as an unchanged period, the duty extremes, and the independence of the panel output.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

    localparam int DATA_W = 8;
    localparam int DIV_W  = 7;
    localparam int CNT_W  = 8;
    localparam int EN_BIT = DATA_W - 1;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_DUTY  = 2'd1,
        SEL_PANEL = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] code;
    } ctrl_t;

    // Next control state for a control write: the code moves only while disabled.
    function automatic ctrl_t ctrl_next(input ctrl_t cur, input logic [DATA_W-1:0] d);
        ctrl_t n;
        n.en   = d[EN_BIT];
        n.code = cur.en ? cur.code : d[DIV_W-1:0];
        return n;
    endfunction

endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  duty_pend,
    output logic              panel
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            duty_pend <= '0;
            panel     <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL:  ctrl      <= ctrl_next(ctrl, wr_data);
                SEL_DUTY:  duty_pend <= wr_data[CNT_W-1:0];
                SEL_PANEL: panel     <= wr_data[0];
                default:   ;
            endcase
        end
    end

    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_CTRL && ctrl.en) |=> $stable(ctrl.code));

    // R4
    code_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_CTRL && !ctrl.en) |=> (ctrl.code == $past(wr_data[DIV_W-1:0])));

endmodule

// File: rtl/bl_pwm_prescale.sv
module bl_pwm_prescale #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] code,
    output logic             tick
);

    logic [DIV_W-1:0] psc;

    always_ff @(posedge clk) begin
        if (rst || !en)
            psc <= '0;
        else if (psc >= code)
            psc <= '0;
        else
            psc <= psc + 1'b1;
    end

    assign tick = en && (psc == code);

    // R2
    psc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (psc <= code));

    // R8
    psc_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> (psc == '0));

endmodule

// File: rtl/bl_pwm_counter.sv
module bl_pwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] duty_pend,
    output logic             pwm
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] duty_act;
    logic             wrap;

    assign wrap = tick && (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            duty_act <= '0;
        else if (!en || wrap)
            duty_act <= duty_pend;
    end

    assign pwm = en && (cnt < duty_act);

    // R6
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap) |=> $stable(duty_act));

    // R8
    cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> (cnt == '0));

    // R5
    duty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (duty_act == '0) |-> !pwm);

endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
    import bl_pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    output logic        pwm_out,
    output logic        panel_en_out
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] duty_pend;
    logic             tick;

    bl_pwm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ctrl      (ctrl),
        .duty_pend (duty_pend),
        .panel     (panel_en_out)
    );

    bl_pwm_prescale #(.DIV_W(DIV_W)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl.en),
        .code (ctrl.code),
        .tick (tick)
    );

    bl_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.en),
        .tick      (tick),
        .duty_pend (duty_pend),
        .pwm       (pwm_out)
    );

    // R7
    off_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CTRL && !wr_data[EN_BIT]) |=> !pwm_out);

endmodule

// File: tb/bl_pwm_top_tb.sv
module bl_pwm_top_tb;

    typedef struct {
        logic  pwm;
        logic  panel;
        string req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out;
    logic       panel_en_out;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    logic  m_panel = 1'b0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    bl_pwm_top u_dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .pwm_out      (pwm_out),
        .panel_en_out (panel_en_out)
    );

    function automatic logic wave(input int k, input int r, input int d);
        return ((k / r) % 256) < d;
    endfunction

    // Driver: one call per clock; expectation is for the state after the next edge.
    task automatic cyc(input logic we, input logic [1:0] sel, input logic [7:0] d,
                       input logic ep, input string req);
        item_t it;
        @(negedge clk);
        wr_en   = we;
        wr_sel  = sel;
        wr_data = d;
        if (we && sel == 2'd2) m_panel = d[0];
        it.pwm   = ep;
        it.panel = m_panel;
        it.req   = req;
        q.push_back(it);
    endtask

    task automatic idle(input logic ep, input string req);
        cyc(1'b0, 2'd0, 8'd0, ep, req);
    endtask

    // Monitor
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                it = q.pop_front();
                n_chk++;
                if (pwm_out !== it.pwm || panel_en_out !== it.panel) begin
                    n_bad++;
                    $display("FAIL %s: pwm=%b panel=%b expected pwm=%b panel=%b",
                             it.req, pwm_out, panel_en_out, it.pwm, it.panel);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then idle after release
        repeat (3) idle(1'b0, "R1");
        @(negedge clk);
        rst = 1'b0;
        repeat (4) idle(1'b0, "R1");

        // Setup: duty 64, panel on, enable with ratio 2
        cyc(1'b1, 2'd1, 8'd64, 1'b0, "R6");
        cyc(1'b1, 2'd2, 8'd1, 1'b0, "R9");
        cyc(1'b1, 2'd0, 8'h81, wave(0, 2, 64), "R2");
        for (int k = 1; k < 100; k++) idle(wave(k, 2, 64), "R5");
        // R6: mid-period duty write held until wrap
        cyc(1'b1, 2'd1, 8'd200, wave(100, 2, 64), "R6");
        for (int k = 101; k < 512; k++) idle(wave(k, 2, 64), "R6");
        for (int k = 512; k < 1024; k++) idle(wave(k, 2, 200), "R2");
        // R3: divider change while enabled is ignored; period stays at ratio 2
        cyc(1'b1, 2'd0, 8'h83, wave(1024, 2, 200), "R3");
        for (int k = 1025; k < 1536; k++) idle(wave(k, 2, 200), "R3");
        // R9: select 3 has no effect
        cyc(1'b1, 2'd3, 8'hFF, wave(1536, 2, 200), "R9");
        for (int k = 1537; k < 1600; k++) idle(wave(k, 2, 200), "R9");

        // R7: disable forces low; code in this write ignored, panel untouched
        cyc(1'b1, 2'd0, 8'h05, 1'b0, "R7");
        for (int k = 0; k < 20; k++) idle(1'b0, "R7");

        // R4: new code with enable in one write while disabled -> ratio 4
        cyc(1'b1, 2'd0, 8'h83, wave(0, 4, 200), "R4");
        for (int k = 1; k < 8; k++) idle(wave(k, 4, 200), "R8");
        for (int k = 8; k < 300; k++) idle(wave(k, 4, 200), "R4");
        // R9: panel off does not touch the PWM
        cyc(1'b1, 2'd2, 8'd0, wave(300, 4, 200), "R9");
        for (int k = 301; k < 1030; k++) idle(wave(k, 4, 200), "R4");

        // R5: duty 0 at ratio 1 stays low
        cyc(1'b1, 2'd0, 8'h00, 1'b0, "R7");
        cyc(1'b1, 2'd0, 8'h00, 1'b0, "R4");
        cyc(1'b1, 2'd1, 8'd0, 1'b0, "R5");
        cyc(1'b1, 2'd0, 8'h80, 1'b0, "R5");
        for (int k = 1; k < 300; k++) idle(1'b0, "R5");

        // R5/R6: duty 255 written while disabled applies from enable
        cyc(1'b1, 2'd0, 8'h00, 1'b0, "R7");
        cyc(1'b1, 2'd1, 8'd255, 1'b0, "R6");
        cyc(1'b1, 2'd0, 8'h80, wave(0, 1, 255), "R8");
        for (int k = 1; k < 512; k++) idle(wave(k, 1, 255), "R5");

        idle(wave(512, 1, 255), "R5");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule